// File: doc/BRIEF.md
# APB Register-Bank Completer

This block is a peripheral shell for a shared APB bus. Behind it sit a few 32-bit read/write registers and no functional core. Every completer on a shared bus has to decide for itself whether a transfer is meant for it. This one compares the bus address against an inclusive window that runs from a base address parameter up to a high address parameter. It only looks at the address when the select line is high and the enable line is low, which is the setup phase of the transfer.

When a transfer is claimed, the block records its kind in one of two flag registers: one for reads and one for writes. On the same clock edge it does one of two things. A write updates the addressed register, one byte lane at a time under the strobes. A read loads the addressed register into a dedicated read-data register. The ready output is the OR of the two flags, so it is high for exactly one cycle, during the access phase. While no claimed transfer is being completed, both ready and read data stay at zero, so the outputs of several completers can be ORed onto the bus.

Top module: `apb_regbank`

## Requirements
- R1: While `rst` is high at a rising clock edge, the edge clears all registers, both flags and the read-data register, so `pready` = 0 and `prdata` = 0 afterwards, and every register later reads back as 0.
- R2: A transfer is claimed only when `paddr` is greater than or equal to `BASE` and less than or equal to `HIGH`, both bounds included. A claimed transfer drives `pready` high in the access-phase cycle.
- R3: A transfer whose address is below `BASE` or above `HIGH` gets no `pready` and changes no register.
- R4: A transfer is claimed only in a cycle where `psel` = 1 and `penable` = 0. A transfer presented with `psel` = 0, or with `penable` already 1 in its first cycle, gets no `pready` and changes no register.
- R5: `pwrite` = 1 in the setup phase marks a write and `pwrite` = 0 marks a read.
- R6: On a write, byte lane k (bits 8k+7 down to 8k) of the target register takes `pwdata` only when `pstrb[k]` = 1. Otherwise the lane keeps its value.
- R7: The target register is selected by bits [3:2] of (`paddr` − `BASE`): offsets 0x0, 0x4, 0x8 and 0xC select registers 0 to 3.
- R8: On a claimed read, `prdata` in the access-phase cycle equals the current contents of the addressed register.
- R9: `pready` stays high for exactly one cycle per claimed transfer and is low in the cycle after it.
- R10: Whenever `pready` is low, `prdata` is 0. During the access phase of a write, `prdata` is also 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| psel | input | 1 | Bus select for this transfer |
| penable | input | 1 | High in the access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| pstrb | input | 4 | Byte-lane write strobes |
| prdata | output | 32 | Read data, 0 when idle |
| pready | output | 1 | One-cycle transfer completion |

## Verification
The assertions assume that the requester follows the two-phase protocol. A setup cycle with `penable` low is always followed by an access cycle with `penable` high, and the address is not changed in between. The properties that link a claimed setup cycle to the next ready pulse rely on this. The stimulus only issues complete setup-plus-access pairs with an idle cycle after each one. The one exception is the deliberate case where `penable` is already high in a transfer's first cycle, which the checker must see as unclaimed. All addresses in the sweep are word aligned.

// File: rtl/apb_rb_pkg.sv
package apb_rb_pkg;
    localparam int DATA_W = 32;
    localparam int STRB_W = DATA_W / 8;
    localparam int LANE_W = 8;

    typedef enum logic [1:0] {
        XF_IDLE  = 2'd0,
        XF_READ  = 2'd1,
        XF_WRITE = 2'd2
    } xf_kind_e;

    function automatic logic in_window(input logic [63:0] a,
                                       input logic [63:0] lo,
                                       input logic [63:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction
endpackage

// File: rtl/apb_rb_decode.sv
module apb_rb_decode
    import apb_rb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE = 16'h0040,
    parameter logic [ADDR_W-1:0] HIGH = 16'h004F,
    parameter int IDX_W = 2
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output xf_kind_e          kind,
    output logic [IDX_W-1:0]  idx
);
    logic [ADDR_W-1:0] offset;
    logic              hit;

    assign offset = paddr - BASE;
    assign idx    = offset[IDX_W+1:2];
    assign hit    = psel && !penable &&
                    in_window(64'(paddr), 64'(BASE), 64'(HIGH));

    always_comb begin
        if (!hit)        kind = XF_IDLE;
        else if (pwrite) kind = XF_WRITE;
        else             kind = XF_READ;
    end
endmodule

// File: rtl/apb_rb_store.sv
module apb_rb_store
    import apb_rb_pkg::*;
#(
    parameter int NREG  = 4,
    parameter int IDX_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  xf_kind_e          kind,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] strb,
    output logic [DATA_W-1:0] regs [NREG]
);
    for (genvar r = 0; r < NREG; r++) begin : g_reg
        for (genvar b = 0; b < STRB_W; b++) begin : g_lane
            always_ff @(posedge clk) begin
                if (rst)
                    regs[r][b*LANE_W +: LANE_W] <= '0;
                else if (kind == XF_WRITE && idx == IDX_W'(r) && strb[b])
                    regs[r][b*LANE_W +: LANE_W] <= wdata[b*LANE_W +: LANE_W];
            end
        end
    end
endmodule

// File: rtl/apb_rb_resp.sv
module apb_rb_resp
    import apb_rb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  xf_kind_e          kind,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] prdata,
    output logic              pready
);
    logic rd_flag, wr_flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_flag <= 1'b0;
            wr_flag <= 1'b0;
            prdata  <= '0;
        end else begin
            rd_flag <= (kind == XF_READ);
            wr_flag <= (kind == XF_WRITE);
            prdata  <= (kind == XF_READ) ? rd_word : '0;
        end
    end

    assign pready = rd_flag | wr_flag;
endmodule

// File: rtl/apb_regbank.sv
module apb_regbank
    import apb_rb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE = 16'h0040,
    parameter logic [ADDR_W-1:0] HIGH = 16'h004F,
    parameter int NREG = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    input  logic [3:0]        pstrb,
    output logic [31:0]       prdata,
    output logic              pready
);
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

    xf_kind_e          kind;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] regs [NREG];
    logic [DATA_W-1:0] rd_word;

    apb_rb_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .HIGH(HIGH), .IDX_W(IDX_W)) u_dec (
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .kind(kind), .idx(idx)
    );

    apb_rb_store #(.NREG(NREG), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst(rst), .kind(kind), .idx(idx),
        .wdata(pwdata), .strb(pstrb), .regs(regs)
    );

    assign rd_word = regs[idx];

    apb_rb_resp u_resp (
        .clk(clk), .rst(rst), .kind(kind), .rd_word(rd_word),
        .prdata(prdata), .pready(pready)
    );
endmodule

// File: rtl/apb_regbank_chk.sv
module apb_regbank_chk #(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE = 16'h0040,
    parameter logic [ADDR_W-1:0] HIGH = 16'h004F
) (
    input logic              clk,
    input logic              rst,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [31:0]       prdata,
    input logic              pready
);
    // R2
    claim_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (psel && !penable && paddr >= BASE && paddr <= HIGH) |=> pready);

    // R3
    outside_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (paddr < BASE || paddr > HIGH) |=> !pready);

    // R4
    access_no_claim_chk: assert property (@(posedge clk) disable iff (rst)
        (penable || !psel) |=> !pready);

    // R9
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        pready |=> !pready);

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !pready |-> prdata == 32'd0);

    // R10
    write_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (psel && !penable && pwrite) |=> prdata == 32'd0);
endmodule

bind apb_regbank apb_regbank_chk #(.ADDR_W(ADDR_W), .BASE(BASE), .HIGH(HIGH)) u_chk (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .prdata(prdata), .pready(pready)
);

// File: tb/apb_regbank_bench.sv
module apb_regbank_bench;
    localparam int CLK_P = 10;
    localparam int ADDR_W = 16;
    localparam logic [ADDR_W-1:0] BASE = 16'h0040;
    localparam logic [ADDR_W-1:0] HIGH = 16'h004F;

    logic clk = 1'b0;
    logic rst;
    logic psel, penable, pwrite;
    logic [ADDR_W-1:0] paddr;
    logic [31:0] pwdata, prdata;
    logic [3:0] pstrb;
    logic pready;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] mdl [4];

    always #(CLK_P/2) clk = ~clk;

    apb_regbank #(.ADDR_W(ADDR_W), .BASE(BASE), .HIGH(HIGH), .NREG(4)) u_apb_regbank (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .prdata(prdata), .pready(pready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                          input logic [3:0] s);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (s[b]) r[b*8 +: 8] = nw[b*8 +: 8];
        return r;
    endfunction

    // one setup+access pair, then one idle cycle; checks response against the model
    task automatic xfer(input logic sel, input logic wr, input logic [ADDR_W-1:0] a,
                        input logic [31:0] d, input logic [3:0] s, input string req);
        logic hit;
        int i;
        hit = sel && (a >= BASE) && (a <= HIGH);
        i = int'((a - BASE) >> 2) & 3;
        @(negedge clk);
        psel = sel; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d; pstrb = s;
        @(negedge clk);
        penable = sel;
        #1;
        chk({req, " pready"}, 32'(pready), 32'(hit));
        chk({req, " prdata"}, prdata, (hit && !wr) ? mdl[i] : 32'd0);
        if (hit && wr) mdl[i] = merge(mdl[i], d, s);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
        #1;
        chk({req, " R9 pulse ends"}, 32'(pready), 32'd0);
        chk({req, " R10 idle data"}, prdata, 32'd0);
    endtask

    task automatic read_all(input string req);
        for (int r = 0; r < 4; r++)
            xfer(1'b1, 1'b0, BASE + ADDR_W'(4*r), 32'd0, 4'd0, req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < 4; r++) mdl[r] = 32'd0;
        rst = 1'b1; psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0; pstrb = '0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 pready reset", 32'(pready), 32'd0);
        chk("R1 prdata reset", prdata, 32'd0);
        rst = 1'b0;
        read_all("R1 regs zero R8");

        // R6 R7 R5: every strobe pattern on every register
        for (int r = 0; r < 4; r++) begin
            for (int s = 0; s < 16; s++) begin
                xfer(1'b1, 1'b1, BASE + ADDR_W'(4*r),
                     32'h1357_9BDF * (r*16 + s + 1), 4'(s), "R6 R7 R5 write");
                xfer(1'b1, 1'b0, BASE + ADDR_W'(4*r), 32'd0, 4'd0, "R8 R6 readback");
            end
        end

        // R2 R3: address sweep across both window edges
        for (int k = -4; k <= 7; k++) begin
            logic [ADDR_W-1:0] a;
            a = BASE + ADDR_W'(4*k);
            xfer(1'b1, 1'b1, a, 32'hA5A5_0000 + 32'(k + 8), 4'hF, "R2 R3 window write");
            read_all("R3 regs after sweep");
        end
        xfer(1'b1, 1'b0, HIGH - 16'd3, 32'd0, 4'd0, "R2 top word read");
        xfer(1'b1, 1'b0, HIGH + 16'd1, 32'd0, 4'd0, "R3 above high read");
        xfer(1'b1, 1'b0, BASE - 16'd1, 32'd0, 4'd0, "R3 below base read");

        // R4: psel low transfer
        xfer(1'b0, 1'b1, BASE, 32'hDEAD_BEEF, 4'hF, "R4 psel low");
        read_all("R4 regs after psel low");

        // R4: enable already high in the first cycle
        @(negedge clk);
        psel = 1; penable = 1; pwrite = 1; paddr = BASE + 16'd4; pwdata = 32'hFFFF_FFFF; pstrb = 4'hF;
        @(negedge clk);
        #1;
        chk("R4 enable-high no ready", 32'(pready), 32'd0);
        chk("R10 enable-high no data", prdata, 32'd0);
        psel = 0; penable = 0;
        read_all("R4 regs after enable-high");

        // R1: reset mid-run clears the bank
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int r = 0; r < 4; r++) mdl[r] = 32'd0;
        read_all("R1 regs after reset");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule